// File: doc/BRIEF.md
# Byte-Counted Sample FIFO

This block buffers 16-bit converter results for a host bus. The converter side hands each result over as two byte pushes, low byte first. The host side pulls data either one byte or one full 16-bit word per access. Throughout, the block keeps an occupancy count in bytes rather than in samples.

A clear command empties the buffer in one clock. The count is exposed through two 8-bit depth views. The lower view carries the live low eight bits of the count. Reading the lower view also freezes the whole count, and the upper view then shows the frozen upper bits. A host reading lower then upper therefore gets one consistent 13-bit value.

Stored data is byte-addressed in a ring. A word access that starts on an odd byte position returns the two next bytes in order, whatever the sample alignment.

Top module: `byte_count_fifo`

## Requirements
- R1: After reset, the count, the overflow flag, the frozen depth value and `rd_data` are all zero.
- R2: `fifo_clr` sampled high at a clock edge sets the count, both ring pointers, the overflow flag, the frozen depth value and `rd_data` to zero at that edge. A push or read in the same cycle has no effect. The next pushed byte is the next byte read.
- R3: A push accepted while not full stores `push_byte` and raises the count by one.
- R4: A byte read (`rd_en`=1, `rd_word`=0) with at least one byte stored returns the oldest byte on `rd_data[7:0]` and zero on `rd_data[15:8]` in the cycle after the request. It lowers the count by one.
- R5: A word read (`rd_en`=1, `rd_word`=1) with at least two bytes stored returns the oldest byte on `rd_data[7:0]` and the next one on `rd_data[15:8]`. It lowers the count by two in a single step.
- R6: A word read that starts at an odd byte position, after an earlier byte read, still returns the two oldest bytes in order.
- R7: A read of either size with nothing stored returns zero on `rd_data` and leaves the count unchanged.
- R8: A word read with exactly one byte stored returns that byte on `rd_data[7:0]` and zero above it, and lowers the count by one.
- R9: When a push and a read fall in the same cycle, the count changes by the bytes accepted minus the bytes removed. The read sees only the bytes present before that cycle.
- R10: Capacity is 8190 bytes (4095 samples). A push while the count is 8190 is dropped even if a read shares the cycle. It sets `overflow`, which stays high until `fifo_clr` or reset.
- R11: `depth_lo` always shows count bits 7..0. A `depth_lo_rd` pulse freezes the full 13-bit count at that edge. `depth_hi` shows frozen bits 12..8 in its bits 4..0 and zero in bits 7..5, and it changes only at the next freeze, clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_clr | input | 1 | Clear command, one cycle |
| push_valid | input | 1 | Converter byte push strobe |
| push_byte | input | 8 | Converter byte, low byte of a sample first |
| rd_en | input | 1 | Host read strobe |
| rd_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |
| depth_lo_rd | input | 1 | Host read of the lower depth view; freezes the count |
| depth_lo | output | 8 | Live count bits 7..0 |
| depth_hi | output | 8 | Frozen count bits 12..8, upper three bits zero |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
A converter push and a host read can share a clock edge. The bench forces this by raising `push_valid` and `rd_en` in the same cycle, both with data already stored and with the buffer full. It then judges the outcome from the returned word and from the depth views read afterwards. A clear command is also issued while a push and a read are pending, to confirm that it wins over both.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_ONE  = 2'd1,
        TAKE_TWO  = 2'd2
    } take_e;
endpackage

// File: rtl/bcf_store.sv
module bcf_store #(
    parameter int PTR_W = 13
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  bcf_pkg::byte_t   wr_byte,
    input  logic [PTR_W-1:0] ra0,
    input  logic [PTR_W-1:0] ra1,
    output bcf_pkg::byte_t   rb0,
    output bcf_pkg::byte_t   rb1
);
    localparam int WORDS = 2 ** (PTR_W - 1);

    bcf_pkg::byte_t lane_rd0 [2];
    bcf_pkg::byte_t lane_rd1 [2];

    // one byte lane per half of a sample; lane chosen by pointer bit 0
    for (genvar g = 0; g < 2; g++) begin : g_lane
        bcf_pkg::byte_t mem [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr[0] == 1'(g))) begin
                mem[wr_addr[PTR_W-1:1]] <= wr_byte;
            end
        end

        assign lane_rd0[g] = mem[ra0[PTR_W-1:1]];
        assign lane_rd1[g] = mem[ra1[PTR_W-1:1]];
    end

    assign rb0 = lane_rd0[ra0[0]];
    assign rb1 = lane_rd1[ra1[0]];
endmodule

// File: rtl/bcf_ctrl.sv
module bcf_ctrl #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push_valid,
    input  bcf_pkg::byte_t   push_byte,
    input  logic             rd_en,
    input  logic             rd_word,
    input  bcf_pkg::byte_t   rb0,
    input  bcf_pkg::byte_t   rb1,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic [15:0]      rd_data
);
    import bcf_pkg::*;

    localparam int CAP = 2 ** CNT_W - 2;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wp;
        logic [CNT_W-1:0] rp;
        logic             ovf;
        logic [15:0]      rdat;
    } st_t;

    st_t   st_d, st_q;
    take_e take;
    logic  push_ok;
    byte_t lo_b, hi_b;

    always_comb begin
        st_d = st_q;
        take = TAKE_NONE;
        if (rd_en) begin
            if (rd_word && st_q.cnt >= CNT_W'(2)) begin
                take = TAKE_TWO;
            end else if (st_q.cnt != '0) begin
                take = TAKE_ONE;
            end
        end
        push_ok = push_valid && (st_q.cnt < CAP_V);

        lo_b = (take != TAKE_NONE) ? rb0 : '0;
        hi_b = (take == TAKE_TWO)  ? rb1 : '0;
        if (rd_en) begin
            st_d.rdat = {hi_b, lo_b};
        end

        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(take);
        st_d.wp  = st_q.wp + CNT_W'(push_ok);
        st_d.rp  = st_q.rp + CNT_W'(take);
        st_d.ovf = st_q.ovf | (push_valid & ~push_ok);

        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = push_ok && !clr;
    assign wr_ptr   = st_q.wp;
    assign rd_ptr   = st_q.rp;
    assign count    = st_q.cnt;
    assign overflow = st_q.ovf;
    assign rd_data  = st_q.rdat;

    logic unused_b;
    assign unused_b = ^push_byte;

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CAP_V);

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !rd_en && !clr && st_q.cnt == CAP_V)
        |=> (st_q.cnt == CAP_V && st_q.ovf));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr) |=> st_q.ovf);

    // R2
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && st_q.wp == '0 && st_q.rp == '0 && !st_q.ovf));

    // R5
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_word && !push_valid && !clr && st_q.cnt >= CNT_W'(2))
        |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(2)));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !push_valid && !clr && st_q.cnt == '0)
        |=> (st_q.cnt == '0 && st_q.rdat == 16'h0));
endmodule

// File: rtl/bcf_depth.sv
module bcf_depth #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lo_rd,
    input  logic [CNT_W-1:0] count,
    output logic [7:0]       depth_lo,
    output logic [7:0]       depth_hi
);
    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0] snap;
    } dst_t;

    dst_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (lo_rd) begin
            d_d.snap = count;
        end
        if (clr) begin
            d_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign depth_lo = count[7:0];
    assign depth_hi = 8'(d_q.snap[CNT_W-1:CNT_W-HI_W]);

    // R11
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !clr) |=> (d_q.snap == $past(count)));

    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_rd && !clr) |=> $stable(depth_hi));
endmodule

// File: rtl/byte_count_fifo.sv
module byte_count_fifo #(
    parameter int CNT_W = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_clr,
    input  logic        push_valid,
    input  logic [7:0]  push_byte,
    input  logic        rd_en,
    input  logic        rd_word,
    output logic [15:0] rd_data,
    input  logic        depth_lo_rd,
    output logic [7:0]  depth_lo,
    output logic [7:0]  depth_hi,
    output logic        overflow
);
    logic             wr_en;
    logic [CNT_W-1:0] wr_ptr, rd_ptr, rd_ptr_nx, count;
    logic [7:0]       rb0, rb1;

    assign rd_ptr_nx = rd_ptr + CNT_W'(1);

    bcf_store #(.PTR_W(CNT_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_byte (push_byte),
        .ra0     (rd_ptr),
        .ra1     (rd_ptr_nx),
        .rb0     (rb0),
        .rb1     (rb1)
    );

    bcf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push_valid (push_valid),
        .push_byte  (push_byte),
        .rd_en      (rd_en),
        .rd_word    (rd_word),
        .rb0        (rb0),
        .rb1        (rb1),
        .wr_en      (wr_en),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count      (count),
        .overflow   (overflow),
        .rd_data    (rd_data)
    );

    bcf_depth #(.CNT_W(CNT_W)) u_depth (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .lo_rd    (depth_lo_rd),
        .count    (count),
        .depth_lo (depth_lo),
        .depth_hi (depth_hi)
    );
endmodule

// File: tb/byte_count_fifo_tb.sv
module byte_count_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP = 8190;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_byte = '0;
    logic        rd_en = 1'b0;
    logic        rd_word = 1'b0;
    logic        depth_lo_rd = 1'b0;
    logic [15:0] rd_data;
    logic [7:0]  depth_lo, depth_hi;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] bq [$];
    bit exp_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_count_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
        .push_valid(push_valid), .push_byte(push_byte),
        .rd_en(rd_en), .rd_word(rd_word), .rd_data(rd_data),
        .depth_lo_rd(depth_lo_rd), .depth_lo(depth_lo),
        .depth_hi(depth_hi), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_one(input logic [7:0] b);
        push_valid = 1'b1;
        push_byte  = b;
        @(negedge clk);
        push_valid = 1'b0;
        if (bq.size() < CAP) bq.push_back(b);
        else exp_ovf = 1;
    endtask

    // returns rd_data of the access; model updated from requirements
    task automatic host_read(input bit word, output logic [15:0] got, output logic [15:0] exp);
        rd_en = 1'b1;
        rd_word = word;
        @(negedge clk);
        rd_en = 1'b0;
        rd_word = 1'b0;
        got = rd_data;
        exp = '0;
        if (bq.size() > 0) exp[7:0] = bq.pop_front();
        if (word && bq.size() > 0 && exp !== 16'hx) begin
            if (bq.size() >= 1 && got[15:8] !== 8'h00 || bq.size() >= 1) exp[15:8] = bq.pop_front();
        end
    endtask

    task automatic read_depth(output int d, output logic [7:0] hi);
        logic [7:0] lo;
        depth_lo_rd = 1'b1;
        lo = depth_lo;
        @(negedge clk);
        depth_lo_rd = 1'b0;
        hi = depth_hi;
        d = {hi[4:0], lo};
    endtask

    task automatic t_reset();
        int d; logic [7:0] hi;
        check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);
        check(depth_hi == 8'h0, "R1 depth_hi", depth_hi, 0);
        read_depth(d, hi);
        check(d == 0, "R1 count", d, 0);
    endtask

    task automatic t_bytes_words();
        int d; logic [7:0] hi; logic [15:0] g, e;
        for (int i = 0; i < 5; i++) push_one(8'h10 + 8'(i));
        read_depth(d, hi);
        check(d == 5, "R3 count after 5 pushes", d, 5);
        host_read(1'b0, g, e);
        check(g == e && g == 16'h0010, "R4 byte read", g, e);
        read_depth(d, hi);
        check(d == 4, "R4 count -1", d, 4);
        host_read(1'b1, g, e);
        check(g == e && g == 16'h1211, "R6 odd word read", g, e);
        read_depth(d, hi);
        check(d == 2, "R5 count -2", d, 2);
        host_read(1'b1, g, e);
        check(g == 16'h1413, "R5 word read", g, 16'h1413);
    endtask

    task automatic t_empty_partial();
        int d; logic [7:0] hi; logic [15:0] g, e;
        host_read(1'b0, g, e);
        check(g == 16'h0, "R7 empty byte read", g, 0);
        host_read(1'b1, g, e);
        check(g == 16'h0, "R7 empty word read", g, 0);
        read_depth(d, hi);
        check(d == 0, "R7 count unchanged", d, 0);
        push_one(8'hA7);
        host_read(1'b1, g, e);
        check(g == 16'h00A7, "R8 word read one byte", g, 16'h00A7);
        read_depth(d, hi);
        check(d == 0, "R8 count -1", d, 0);
    endtask

    task automatic t_same_cycle();
        int d; logic [7:0] hi; logic [15:0] g;
        push_one(8'h21);
        push_one(8'h43);
        push_valid = 1'b1; push_byte = 8'h65; rd_en = 1'b1; rd_word = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; rd_en = 1'b0; rd_word = 1'b0;
        g = rd_data;
        void'(bq.pop_front()); void'(bq.pop_front()); bq.push_back(8'h65);
        check(g == 16'h4321, "R9 word with push", g, 16'h4321);
        read_depth(d, hi);
        check(d == 1, "R9 net count", d, 1);
        // read at empty while a push lands
        host_read_keep();
        push_valid = 1'b1; push_byte = 8'h99; rd_en = 1'b1; rd_word = 1'b0;
        @(negedge clk);
        push_valid = 1'b0; rd_en = 1'b0;
        check(rd_data == 16'h0, "R9 read sees prior bytes only", rd_data, 0);
        read_depth(d, hi);
        check(d == 1, "R9 push during empty read", d, 1);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        check(rd_data == 16'h0099, "R9 pushed byte later read", rd_data, 16'h99);
        bq.delete();
    endtask

    task automatic host_read_keep();
        rd_en = 1'b1; rd_word = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == 16'h0065, "R4 byte read after net", rd_data, 16'h65);
        void'(bq.pop_front());
    endtask

    task automatic t_clear();
        int d; logic [7:0] hi;
        push_one(8'h01); push_one(8'h02); push_one(8'h03);
        read_depth(d, hi);
        fifo_clr = 1'b1; push_valid = 1'b1; push_byte = 8'hEE; rd_en = 1'b1; rd_word = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0; push_valid = 1'b0; rd_en = 1'b0; rd_word = 1'b0;
        bq.delete();
        check(rd_data == 16'h0, "R2 rd_data cleared", rd_data, 0);
        check(depth_lo == 8'h0, "R2 count cleared", depth_lo, 0);
        push_one(8'h5C);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        void'(bq.pop_front());
        check(rd_data == 16'h005C, "R2 fresh data after clear", rd_data, 16'h5C);
    endtask

    task automatic t_full();
        int d; logic [7:0] hi; logic [15:0] g, e;
        for (int i = 0; i < CAP; i++) push_one(8'(i) ^ 8'h5A);
        read_depth(d, hi);
        check(d == CAP, "R10 full count", d, CAP);
        check(hi == 8'h1F, "R11 depth_hi bits", hi, 8'h1F);
        check(overflow == 1'b0, "R10 no overflow yet", overflow, 0);
        push_one(8'hFF);
        read_depth(d, hi);
        check(d == CAP, "R10 push dropped", d, CAP);
        check(overflow == 1'b1, "R10 overflow set", overflow, 1);
        push_valid = 1'b1; push_byte = 8'hFE; rd_en = 1'b1; rd_word = 1'b0;
        @(negedge clk);
        push_valid = 1'b0; rd_en = 1'b0;
        g = rd_data; e = {8'h00, bq.pop_front()};
        check(g == e, "R10 read while full push", g, e);
        read_depth(d, hi);
        check(d == CAP - 1, "R10 push dropped with read", d, CAP - 1);
        host_read(1'b1, g, e);
        check(g == e, "R6 word at odd position when full", g, e);
        check(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
        // frozen upper view holds while count drops below 0x1F00
        read_depth(d, hi);
        for (int i = 0; i < 300; i++) begin
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
            void'(bq.pop_front());
        end
        check(depth_hi == 8'h1F, "R11 depth_hi held", depth_hi, 8'h1F);
        read_depth(d, hi);
        check(d == bq.size(), "R11 new snapshot", d, bq.size());
        check(hi == 8'h1E && hi[7:5] == 3'b0, "R11 upper view", hi, 8'h1E);
        fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
        bq.delete();
        check(overflow == 1'b0, "R2 overflow cleared", overflow, 0);
        check(depth_hi == 8'h0, "R2 snapshot cleared", depth_hi, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes_words();
        t_empty_partial();
        t_same_cycle();
        t_clear();
        t_full();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule